// File: doc/BRIEF.md
# Programmable Interval Counter Channel

This block is one channel of an interval timer: a down-counter, 16 bits wide by default, that runs from the channel clock, watches a GATE input and drives one OUT line. A host-side block, kept separate, decodes the bus and assembles bytes. It hands this channel a control word (a 3-bit mode code and a decimal-count select) with a one-cycle strobe. It also hands over a full count value with its own one-cycle load strobe. In return the channel shows its live count and a flag that goes high once the most recently written count has reached the counting element.

There are six behaviours. Mode 0 raises OUT at terminal count. Mode 1 is a retriggerable one-shot started by GATE. Mode 2 divides the clock by N with a one-clock low pulse. Mode 3 makes a square wave of period N. Mode 4 gives a strobe at terminal count, started by writing the count. Mode 5 gives the same strobe, started by a rising edge on GATE. In modes 0, 2, 3 and 4 counting needs GATE high. In modes 1 and 5 a GATE rising edge acts as the trigger.

The counter can count in binary or as four decimal decades. In either case a written value of zero stands for one more than the largest value the counter can hold. Both strobes are plain control pulses that the channel takes on every cycle. There is no back-pressure. The host must not raise a strobe in the same cycle as a GATE rising edge it relies on.

Top module: `pit_channel`

## Requirements
- R1: Reset leaves `tmr_out` high, `count_now` at 0 and `cnt_loaded` low.
- R2: Mode codes 6 and 7 behave exactly as codes 2 and 3. A control word with bit 1 of `cw_mode` set selects mode {0, cw_mode[1:0]}.
- R3: Mode 0: a control word or a count write drives `tmr_out` low on the next clock. The written count N appears on `count_now` one clock later. `tmr_out` rises N+1 clocks after the write and stays high until the next write of either kind.
- R4: In modes 0, 2, 3 and 4, a clock edge that sees `gate` low leaves `count_now` unchanged. In modes 2 and 3, `gate` low also forces `tmr_out` high, and the next `gate` rising edge reloads the count.
- R5: Mode 1: when a count has been written, a `gate` rising edge loads the count and drives `tmr_out` low for N clocks. A new rising edge during the pulse restarts the N-clock pulse. A count written during a pulse does not change that pulse and is used from the next trigger.
- R6: Mode 2: `tmr_out` repeats with period N, low for exactly one clock per period (N >= 2).
- R7: Mode 3: `tmr_out` is a square wave of period N. It is high for ceil(N/2) clocks and low for floor(N/2) clocks (N >= 2).
- R8: Mode 4: after a count write, `tmr_out` stays high for N+1 clocks and then goes low for a single clock. There is no further strobe until the next write.
- R9: Mode 5: with no `gate` rising edge, `tmr_out` stays high. After a rising edge, `tmr_out` stays high for N clocks and then goes low for a single clock.
- R10: With `cw_bcd` set, the count runs in four decimal decades (0x0010 steps to 0x0009). A value of 0 means 10000 clocks in decimal and 65536 in binary.
- R11: `cnt_loaded` is low after a control word or a count write. It goes high when that count is transferred into the counter: on the next clock in modes 0, 2, 3 and 4 when the counter is idle, at the next reload in modes 2 and 3, and at the trigger in modes 1 and 5.
- R12: A control word selecting any mode other than 0 drives `tmr_out` high on the next clock and stops counting until a count is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Channel counting clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| gate | input | 1 | GATE level, synchronous to clk |
| cw_wr | input | 1 | One-cycle strobe: control word written |
| cw_mode | input | 3 | Mode code of the control word |
| cw_bcd | input | 1 | 1 selects decimal-decade counting |
| cnt_wr | input | 1 | One-cycle strobe: count value written |
| cnt_val | input | CNT_W | Count value accompanying cnt_wr |
| tmr_out | output | 1 | OUT waveform |
| count_now | output | CNT_W | Live counter contents |
| cnt_loaded | output | 1 | Last written count has reached the counter |

## Verification
Some rules are checked on every cycle. These are the cycle-to-cycle rules: the OUT level that follows a control word, the single-cycle width of the mode 2, 4 and 5 low pulses, the mode 0 high level holding until a write, the count freezing while GATE is low, mode aliasing, the one-shot start and the loaded flag falling after writes. Only the bench's scenarios can show the waveform lengths: the periods and duty of modes 2 and 3 for even, odd, decimal and zero counts, the N+1 and N delays, retriggering, and the deferred count in mode 1.

// File: rtl/pit_chan_pkg.sv
`timescale 1ns/1ps
package pit_chan_pkg;

  typedef enum logic [2:0] {
    MD_TERM    = 3'd0,
    MD_ONESHOT = 3'd1,
    MD_RATE    = 3'd2,
    MD_SQUARE  = 3'd3,
    MD_SWSTB   = 3'd4,
    MD_HWSTB   = 3'd5
  } mode_e;

  // Codes with bit 1 set ignore bit 2 (6 -> 2, 7 -> 3).
  function automatic mode_e fold_mode(input logic [2:0] code);
    if (code[1]) return mode_e'({1'b0, code[1:0]});
    return mode_e'(code);
  endfunction

endpackage

// File: rtl/pit_decr.sv
`timescale 1ns/1ps
module pit_decr #(
  parameter int W = 16
) (
  input  logic [W-1:0] val,
  input  logic         bcd,
  input  logic         two,
  output logic [W-1:0] nxt
);
  localparam int ND = W / 4;

  logic [W-1:0] bin_res;
  logic [W-1:0] bcd_res;
  logic [1:0]   brw [ND];
  logic [4:0]   sub [ND];

  assign bin_res = val - (two ? W'(2) : W'(1));
  assign brw[0]  = two ? 2'd2 : 2'd1;

  // Ripple borrow through decimal decades.
  for (genvar g = 0; g < ND; g++) begin : g_dig
    assign sub[g] = {1'b0, val[g*4 +: 4]} - {3'b000, brw[g]};
    assign bcd_res[g*4 +: 4] = sub[g][4] ? (sub[g][3:0] + 4'd10) : sub[g][3:0];
    if (g < ND - 1) begin : g_brw
      assign brw[g+1] = {1'b0, sub[g][4]};
    end
  end

  if (ND * 4 < W) begin : g_rest
    assign bcd_res[W-1:ND*4] = val[W-1:ND*4];
  end

  assign nxt = bcd ? bcd_res : bin_res;
endmodule

// File: rtl/pit_gate_edge.sv
`timescale 1ns/1ps
module pit_gate_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic gate,
  output logic rise
);
  logic gate_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) gate_q <= 1'b0;
    else        gate_q <= gate;
  end

  assign rise = gate & ~gate_q;
endmodule

// File: rtl/pit_mode_ctl.sv
`timescale 1ns/1ps
module pit_mode_ctl
  import pit_chan_pkg::*;
#(
  parameter int W = 16
) (
  input  mode_e        mode,
  input  logic         bcd,
  input  logic [W-1:0] init,
  input  logic [W-1:0] cnt,
  input  logic         out,
  input  logic         live,
  input  logic         arm,
  input  logic         pend,
  input  logic         have,
  input  logic         sqx,
  input  logic         gate,
  input  logic         rise,
  input  logic         cw_wr,
  input  logic [2:0]   cw_mode,
  input  logic         cw_bcd,
  input  logic         cnt_wr,
  input  logic [W-1:0] cnt_val,
  output mode_e        n_mode,
  output logic         n_bcd,
  output logic [W-1:0] n_init,
  output logic [W-1:0] n_cnt,
  output logic         n_out,
  output logic         n_live,
  output logic         n_arm,
  output logic         n_pend,
  output logic         n_have,
  output logic         n_sqx
);
  logic [W-1:0] dec;
  logic [W-1:0] sq_load;
  logic         is_one;
  logic         is_two;
  logic         restart;
  mode_e        cw_fold;

  assign is_one  = (cnt == W'(1));
  assign is_two  = (cnt == W'(2));
  assign sq_load = {init[W-1:1], 1'b0};
  assign restart = (pend && !live) || (live && rise);
  assign cw_fold = fold_mode(cw_mode);

  pit_decr #(.W(W)) u_decr (
    .val (cnt),
    .bcd (bcd),
    .two (mode == MD_SQUARE),
    .nxt (dec)
  );

  always_comb begin
    n_mode = mode;
    n_bcd  = bcd;
    n_init = init;
    n_cnt  = cnt;
    n_out  = out;
    n_live = live;
    n_arm  = arm;
    n_pend = pend;
    n_have = have;
    n_sqx  = sqx;

    case (mode)
      MD_TERM, MD_SWSTB: begin
        if (pend) begin
          n_cnt  = init;
          n_pend = 1'b0;
          n_live = 1'b1;
          n_arm  = 1'b1;
          n_out  = (mode == MD_SWSTB);
        end else begin
          if (mode == MD_SWSTB) n_out = 1'b1;
          if (live && gate) begin
            n_cnt = dec;
            if (arm && is_one) begin
              n_arm = 1'b0;
              n_out = (mode == MD_TERM);
            end
          end
        end
      end

      MD_ONESHOT, MD_HWSTB: begin
        if (rise && have) begin
          n_cnt  = init;
          n_pend = 1'b0;
          n_live = 1'b1;
          n_arm  = 1'b1;
          n_out  = (mode == MD_HWSTB);
        end else begin
          if (mode == MD_HWSTB) n_out = 1'b1;
          if (live) begin
            n_cnt = dec;
            if (arm && is_one) begin
              n_arm = 1'b0;
              n_out = (mode == MD_ONESHOT);
            end
          end
        end
      end

      MD_RATE: begin
        if (restart) begin
          n_cnt  = init;
          n_pend = 1'b0;
          n_live = 1'b1;
          n_out  = 1'b1;
        end else if (live && gate) begin
          if (is_one) begin
            n_cnt  = init;
            n_pend = 1'b0;
            n_out  = 1'b1;
          end else begin
            n_cnt = dec;
            n_out = !is_two;
          end
        end else if (live) begin
          n_out = 1'b1;
        end
      end

      MD_SQUARE: begin
        if (restart) begin
          n_cnt  = sq_load;
          n_pend = 1'b0;
          n_live = 1'b1;
          n_out  = 1'b1;
          n_sqx  = 1'b0;
        end else if (live && gate) begin
          if (is_two) begin
            if (out && init[0] && !sqx) begin
              n_sqx = 1'b1;
            end else begin
              n_out  = !out;
              n_cnt  = sq_load;
              n_pend = 1'b0;
              n_sqx  = 1'b0;
            end
          end else begin
            n_cnt = dec;
          end
        end else if (live) begin
          n_out = 1'b1;
        end
      end

      default: ;
    endcase

    if (cnt_wr) begin
      n_init = cnt_val;
      n_pend = 1'b1;
      n_have = 1'b1;
      if (mode == MD_TERM || mode == MD_SWSTB) begin
        n_live = 1'b0;
        n_arm  = 1'b0;
        n_out  = (mode == MD_SWSTB);
      end
    end

    if (cw_wr) begin
      n_mode = cw_fold;
      n_bcd  = cw_bcd;
      n_out  = (cw_fold != MD_TERM);
      n_live = 1'b0;
      n_arm  = 1'b0;
      n_pend = 1'b0;
      n_have = 1'b0;
      n_sqx  = 1'b0;
    end
  end
endmodule

// File: rtl/pit_channel.sv
`timescale 1ns/1ps
module pit_channel
  import pit_chan_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             gate,
  input  logic             cw_wr,
  input  logic [2:0]       cw_mode,
  input  logic             cw_bcd,
  input  logic             cnt_wr,
  input  logic [CNT_W-1:0] cnt_val,
  output logic             tmr_out,
  output logic [CNT_W-1:0] count_now,
  output logic             cnt_loaded
);
  mode_e            mode_q, mode_d;
  logic             bcd_q, bcd_d;
  logic [CNT_W-1:0] init_q, init_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             out_q, out_d;
  logic             live_q, live_d;
  logic             arm_q, arm_d;
  logic             pend_q, pend_d;
  logic             have_q, have_d;
  logic             sqx_q, sqx_d;
  logic             gate_rise;

  pit_gate_edge u_edge (
    .clk   (clk),
    .rst_n (rst_n),
    .gate  (gate),
    .rise  (gate_rise)
  );

  pit_mode_ctl #(.W(CNT_W)) u_ctl (
    .mode    (mode_q),
    .bcd     (bcd_q),
    .init    (init_q),
    .cnt     (cnt_q),
    .out     (out_q),
    .live    (live_q),
    .arm     (arm_q),
    .pend    (pend_q),
    .have    (have_q),
    .sqx     (sqx_q),
    .gate    (gate),
    .rise    (gate_rise),
    .cw_wr   (cw_wr),
    .cw_mode (cw_mode),
    .cw_bcd  (cw_bcd),
    .cnt_wr  (cnt_wr),
    .cnt_val (cnt_val),
    .n_mode  (mode_d),
    .n_bcd   (bcd_d),
    .n_init  (init_d),
    .n_cnt   (cnt_d),
    .n_out   (out_d),
    .n_live  (live_d),
    .n_arm   (arm_d),
    .n_pend  (pend_d),
    .n_have  (have_d),
    .n_sqx   (sqx_d)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MD_TERM;
      bcd_q  <= 1'b0;
      init_q <= '0;
      cnt_q  <= '0;
      out_q  <= 1'b1;
      live_q <= 1'b0;
      arm_q  <= 1'b0;
      pend_q <= 1'b0;
      have_q <= 1'b0;
      sqx_q  <= 1'b0;
    end else begin
      mode_q <= mode_d;
      bcd_q  <= bcd_d;
      init_q <= init_d;
      cnt_q  <= cnt_d;
      out_q  <= out_d;
      live_q <= live_d;
      arm_q  <= arm_d;
      pend_q <= pend_d;
      have_q <= have_d;
      sqx_q  <= sqx_d;
    end
  end

  assign tmr_out    = out_q;
  assign count_now  = cnt_q;
  assign cnt_loaded = have_q & ~pend_q;
endmodule

// File: rtl/pit_channel_chk.sv
`timescale 1ns/1ps
module pit_channel_chk
  import pit_chan_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             gate,
  input logic             cw_wr,
  input logic [2:0]       cw_mode,
  input logic             cnt_wr,
  input logic             tmr_out,
  input logic [CNT_W-1:0] count_now,
  input logic             cnt_loaded,
  input mode_e            mode_q,
  input logic             live_q,
  input logic             have_q,
  input logic             gate_rise
);

  assert_cw_zero_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cw_wr && cw_mode == 3'd0) |=> !tmr_out);

  assert_term_holds_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MD_TERM && tmr_out && !cw_wr && !cnt_wr) |=> tmr_out);

  assert_cw_other_high_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (cw_wr && cw_mode != 3'd0) |=> tmr_out);

  assert_alias_fold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cw_wr && cw_mode[1]) |=> (mode_q == mode_e'({1'b0, $past(cw_mode[1:0])})));

  assert_gate_freeze_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode_q == MD_TERM || mode_q == MD_RATE || mode_q == MD_SQUARE || mode_q == MD_SWSTB)
      && !gate && live_q && !cw_wr && !cnt_wr) |=> $stable(count_now));

  assert_oneshot_start_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MD_ONESHOT && gate_rise && have_q && !cw_wr) |=> !tmr_out);

  assert_rate_single_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MD_RATE && !tmr_out && !cw_wr) |=> tmr_out);

  assert_strobe_single_R8_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode_q == MD_SWSTB || mode_q == MD_HWSTB) && !tmr_out && !cw_wr) |=> tmr_out);

  assert_write_clears_loaded_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (cw_wr || cnt_wr) |=> !cnt_loaded);

endmodule

bind pit_channel pit_channel_chk #(.CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .gate       (gate),
  .cw_wr      (cw_wr),
  .cw_mode    (cw_mode),
  .cnt_wr     (cnt_wr),
  .tmr_out    (tmr_out),
  .count_now  (count_now),
  .cnt_loaded (cnt_loaded),
  .mode_q     (mode_q),
  .live_q     (live_q),
  .have_q     (have_q),
  .gate_rise  (gate_rise)
);

// File: tb/test_pit_channel.sv
`timescale 1ns/1ps
module test_pit_channel;
  localparam int W = 16;
  localparam int NV = 10;
  // {bcd, mode code, count, high clocks, low clocks, requirement id}
  localparam logic [55:0] VEC [NV] = '{
    {1'b0, 3'd2, 16'd2,      16'd1,    16'd1,    4'd6},
    {1'b0, 3'd2, 16'd5,      16'd4,    16'd1,    4'd6},
    {1'b0, 3'd3, 16'd4,      16'd2,    16'd2,    4'd7},
    {1'b0, 3'd3, 16'd5,      16'd3,    16'd2,    4'd7},
    {1'b0, 3'd3, 16'd3,      16'd2,    16'd1,    4'd7},
    {1'b0, 3'd7, 16'd6,      16'd3,    16'd3,    4'd2},
    {1'b0, 3'd6, 16'd3,      16'd2,    16'd1,    4'd2},
    {1'b1, 3'd3, 16'h0015,   16'd8,    16'd7,    4'd10},
    {1'b1, 3'd2, 16'h0000,   16'd9999, 16'd1,    4'd10},
    {1'b1, 3'd3, 16'h0000,   16'd5000, 16'd5000, 4'd10}
  };

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         gate = 1'b0;
  logic         cw_wr = 1'b0;
  logic [2:0]   cw_mode = 3'd0;
  logic         cw_bcd = 1'b0;
  logic         cnt_wr = 1'b0;
  logic [W-1:0] cnt_val = '0;
  logic         tmr_out;
  logic [W-1:0] count_now;
  logic         cnt_loaded;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;
  int lo, hi, tmp;
  logic [W-1:0] held;

  always #2.5 clk = ~clk;

  pit_channel #(.CNT_W(W)) i_pit_channel (
    .clk        (clk),
    .rst_n      (rst_n),
    .gate       (gate),
    .cw_wr      (cw_wr),
    .cw_mode    (cw_mode),
    .cw_bcd     (cw_bcd),
    .cnt_wr     (cnt_wr),
    .cnt_val    (cnt_val),
    .tmr_out    (tmr_out),
    .count_now  (count_now),
    .cnt_loaded (cnt_loaded)
  );

  task automatic check(input string req, input string what, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic put_cw(input logic [2:0] m, input logic b);
    @(negedge clk); cw_mode = m; cw_bcd = b; cw_wr = 1'b1;
    @(negedge clk); cw_wr = 1'b0;
  endtask

  task automatic put_cnt(input logic [W-1:0] v);
    @(negedge clk); cnt_val = v; cnt_wr = 1'b1;
    @(negedge clk); cnt_wr = 1'b0;
  endtask

  // Counts consecutive negedge samples at level lvl, stops on the first other sample.
  task automatic run_len(input logic lvl, output int n);
    n = 0;
    while (tmr_out === lvl && n < 70000) begin
      n++;
      @(negedge clk);
    end
  endtask

  function automatic string req_name(input logic [3:0] id);
    case (id)
      4'd2:    return "R2";
      4'd6:    return "R6";
      4'd7:    return "R7";
      default: return "R10";
    endcase
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1", "reset out", tmr_out, 1);
    check("R1", "reset count", count_now, 0);
    check("R1", "reset loaded", cnt_loaded, 0);
    rst_n = 1'b1;

    // Vector walk: periodic modes, aliases, decimal and zero counts
    for (int i = 0; i < NV; i++) begin
      logic [55:0] r;
      r = VEC[i];
      gate = 1'b1;
      put_cw(r[54:52], r[55]);
      put_cnt(r[51:36]);
      run_len(1'b1, tmp);
      run_len(1'b0, lo);
      run_len(1'b1, hi);
      check(req_name(r[3:0]), "low clocks", lo, r[19:4]);
      check(req_name(r[3:0]), "high clocks", hi, r[35:20]);
    end

    // R3: mode 0 delay, R11 loaded flag
    gate = 1'b1;
    put_cw(3'd0, 1'b0);
    check("R3", "out after control word", tmr_out, 0);
    put_cnt(16'd5);
    check("R3", "out after count write", tmr_out, 0);
    check("R11", "loaded before transfer", cnt_loaded, 0);
    @(negedge clk);
    check("R3", "count after transfer", count_now, 5);
    check("R11", "loaded after transfer", cnt_loaded, 1);
    run_len(1'b0, lo);
    check("R3", "low clocks after transfer", lo, 5);
    repeat (3) @(negedge clk);
    check("R3", "out stays high after terminal", tmr_out, 1);

    // R4: gate low freezes mode 0
    gate = 1'b0;
    put_cw(3'd0, 1'b0);
    put_cnt(16'd20);
    repeat (5) @(negedge clk);
    check("R4", "mode0 count held", count_now, 20);
    gate = 1'b1;
    repeat (3) @(negedge clk);
    check("R4", "mode0 count resumes", count_now, 17);

    // R10: decimal borrow in mode 0
    put_cw(3'd0, 1'b1);
    put_cnt(16'h0010);
    @(negedge clk);
    @(negedge clk);
    check("R10", "decimal step 0x10", count_now, 16'h0009);
    run_len(1'b0, lo);
    check("R10", "decimal low remaining", lo, 9);

    // R8: mode 4 strobe
    put_cw(3'd4, 1'b0);
    check("R12", "out after mode4 control word", tmr_out, 1);
    put_cnt(16'd3);
    run_len(1'b1, hi);
    check("R8", "high before strobe", hi, 4);
    run_len(1'b0, lo);
    check("R8", "strobe width", lo, 1);
    repeat (6) @(negedge clk);
    check("R8", "no second strobe", tmr_out, 1);

    // R9: mode 5 waits for a rising edge
    gate = 1'b0;
    put_cw(3'd5, 1'b0);
    put_cnt(16'd4);
    repeat (8) @(negedge clk);
    check("R9", "no strobe without trigger", tmr_out, 1);
    gate = 1'b1;
    @(negedge clk);
    check("R11", "mode5 loaded at trigger", cnt_loaded, 1);
    run_len(1'b1, hi);
    check("R9", "high after trigger", hi, 4);
    run_len(1'b0, lo);
    check("R9", "strobe width", lo, 1);

    // R5: one-shot, ignored without trigger
    gate = 1'b0;
    put_cw(3'd1, 1'b0);
    put_cnt(16'd3);
    repeat (4) @(negedge clk);
    check("R5", "idle high without trigger", tmr_out, 1);
    gate = 1'b1;
    @(negedge clk);
    run_len(1'b0, lo);
    check("R5", "pulse width", lo, 3);

    // R5: retrigger restarts the pulse
    gate = 1'b0;
    put_cw(3'd1, 1'b0);
    put_cnt(16'd6);
    gate = 1'b1;
    @(negedge clk);
    gate = 1'b0;
    @(negedge clk);
    gate = 1'b1;
    @(negedge clk);
    run_len(1'b0, lo);
    check("R5", "pulse after retrigger", lo, 6);

    // R5: count written mid-pulse is deferred
    gate = 1'b0;
    put_cw(3'd1, 1'b0);
    put_cnt(16'd4);
    gate = 1'b1;
    @(negedge clk);
    put_cnt(16'd9);
    check("R11", "loaded low while deferred", cnt_loaded, 0);
    run_len(1'b0, lo);
    check("R5", "rest of pulse unchanged", lo, 2);
    gate = 1'b0;
    @(negedge clk);
    gate = 1'b1;
    @(negedge clk);
    run_len(1'b0, lo);
    check("R5", "next pulse uses new count", lo, 9);

    // R4: gate low in mode 2 holds count, forces out high, rise reloads
    gate = 1'b1;
    put_cw(3'd2, 1'b0);
    put_cnt(16'd5);
    repeat (3) @(negedge clk);
    gate = 1'b0;
    @(negedge clk);
    held = count_now;
    check("R4", "mode2 out high with gate low", tmr_out, 1);
    repeat (3) @(negedge clk);
    check("R4", "mode2 count held", count_now, held);
    gate = 1'b1;
    @(negedge clk);
    check("R4", "mode2 reload on rise", count_now, 5);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule